// File: doc/BRIEF.md
# SDRAM Mode-Register Write Generator

This block sits on a CPU-style memory bus in front of two SDRAM chip-select areas. Each area owns a 4 KiB address window, and software programs the SDRAM mode register by writing to that window. The write data is thrown away. The offset inside the window becomes the mode value. The block turns an accepted write into one mode-register-set command on the chip select for that area, with the offset driven onto the SDRAM address pins.

Before it issues a command, the block checks the access. The access must be one byte wide. Configuration must already be complete. The offset must decode, for the bus width of the target area, to one of the supported mode words: burst length 1, sequential wrap, CAS latency 2 or 3, and either single-write or burst-write. A write that fails any of these checks is acknowledged with an error, and no command goes out. After a command, a per-area wait of `TMRD` cycles holds off the next command to the same area. Each area's CAS latency from its last accepted command is exported for the read datapath.

Top module: `sdram_mrs_gen`

## Requirements
- R1: A write request (`bus_we`=1) whose address lies in 0xA4FD4000..0xA4FD4FFF targets area index 0 (`sd_cs_n[0]`). An address in 0xA4FD5000..0xA4FD5FFF targets area index 1 (`sd_cs_n[1]`). Any other address, and any read, is ignored: no command and no `bus_ack`.
- R2: A mode-register-set is exactly one clock cycle, starting the cycle after the request is sampled. In that cycle the target area's `sd_cs_n` bit is 0, the other bit is 1, and `sd_ras_n`, `sd_cas_n` and `sd_we_n` are all 0. In every other cycle all four strobes are 1.
- R3: During the command, `sd_addr[11:0]` equals the window offset and `sd_addr[14:12]` (A12 and above) are 0. The value of `bus_wdata` has no effect.
- R4: `bus_size` encodes 00 = byte, 01 = halfword, 10 = word. A window write of any size other than byte is acknowledged with `bus_err`=1 and issues no command.
- R5: While `cfg_done` is 0, a window write is acknowledged with `bus_err`=1 and issues no command.
- R6: `area_wide[i]`=0 selects a 16-bit area, where the mode word is offset>>1 and offset bit 0 must be 0. `area_wide[i]`=1 selects a 32-bit area, where the mode word is offset>>2 and offset bits 1:0 must be 0. The mode word is legal only when bits 2:0 = 0, bit 3 = 0, bits 6:4 = 2 or 3, and bits 8:7 and 11:10 = 0; bit 9 is free. The legal offsets are therefore 0x040, 0x060, 0x440 and 0x460 on a 16-bit area, and 0x080, 0x0C0, 0x880 and 0x8C0 on a 32-bit area. Any other offset gives `bus_err`=1 and no command.
- R7: For an accepted write, `bus_ack` is high for exactly one cycle, the cycle right after the command cycle, with `bus_err`=0. For a rejected write, `bus_ack` and `bus_err` are high for one cycle, the cycle after the request is sampled.
- R8: After a command on an area, at least `TMRD` NOP cycles pass before the next command on that same area. A held request waits, and with the request held its command follows after exactly `TMRD` NOP cycles. The other area is not delayed.
- R9: `cas_lat[2i+1:2i]` resets to 3. It takes the CAS latency (bits 5:4 of the mode word) of each accepted command on area i, and is unchanged by rejected writes and by commands to the other area.
- R10: After reset, all SDRAM strobes are 1, `bus_ack` and `bus_err` are 0, and `cas_lat` reads 3 for both areas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Controller configuration complete |
| area_wide | input | N_AREA | Per-area bus width, 1 = 32-bit, 0 = 16-bit |
| bus_req | input | 1 | Bus request, held until `bus_ack` |
| bus_we | input | 1 | Request is a write |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_size | input | 2 | Access size: 00 byte, 01 half, 10 word |
| bus_wdata | input | DATA_W | Write data (ignored) |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Completion carries an error |
| sd_cs_n | output | N_AREA | Per-area SDRAM chip selects, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_addr | output | SD_AW | SDRAM address pins |
| cas_lat | output | 2*N_AREA | Last programmed CAS latency per area |

## Verification
The bench targets a mode offset that is legal for one bus width but not the other, such as 0x880 on a 16-bit area or 0x440 on a 32-bit area. A design that shifted by the wrong amount, or ignored `area_wide`, would accept these and program a wrong latency. It sends back-to-back requests to one area, and then to alternate areas. A missing or shared tMRD counter shows up as a command gap that is too short, or as the other area being stalled when it should not be. Halfword, word and pre-configuration writes must be rejected without touching `cas_lat`. Out-of-window writes and reads must draw no acknowledge at all. A design that decoded too loosely would respond to them.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;

  // Width of the window offset and of the mode word carried on the pins
  localparam int MW_W = 12;

  // Bus access size code for a byte write
  localparam logic [1:0] SZ_BYTE = 2'b00;

  // Mode word field positions
  localparam int BLEN_LSB  = 0;
  localparam int WRAP_BIT  = 3;
  localparam int LAT_LSB   = 4;
  localparam int WMODE_BIT = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RESP = 2'd2
  } mrs_state_e;

  // True when the mode word is one of the supported combinations
  function automatic logic mode_word_ok(input logic [MW_W-1:0] mw);
    logic [2:0] lat;
    lat = mw[LAT_LSB +: 3];
    return (mw[BLEN_LSB +: 3] == 3'd0)
        && !mw[WRAP_BIT]
        && ((lat == 3'd2) || (lat == 3'd3))
        && (mw[8:7] == 2'b00)
        && (mw[MW_W-1:10] == '0);
  endfunction

  // CAS latency carried by a legal mode word
  function automatic logic [1:0] mode_word_lat(input logic [MW_W-1:0] mw);
    return mw[LAT_LSB +: 2];
  endfunction

endpackage

// File: rtl/mrs_window_decode.sv
module mrs_window_decode
  import sdram_mrs_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              N_AREA     = 2,
  parameter logic [31:0]     WIN_BASE   = 32'hA4FD4000,
  parameter logic [31:0]     WIN_STRIDE = 32'h00001000,
  localparam int             IDX_W      = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  input  logic               cfg_done,
  input  logic [N_AREA-1:0]  area_wide,
  output logic               hit,
  output logic [IDX_W-1:0]   area_idx,
  output logic               legal,
  output logic [MW_W-1:0]    offset,
  output logic [1:0]         lat
);

  logic [N_AREA-1:0] area_hit;

  // One window comparator per area, each on the address bits above the offset
  for (genvar gi = 0; gi < N_AREA; gi++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE_I =
      ADDR_W'(WIN_BASE) + ADDR_W'(gi) * ADDR_W'(WIN_STRIDE);
    assign area_hit[gi] = (addr[ADDR_W-1:MW_W] == BASE_I[ADDR_W-1:MW_W]);
  end

  always_comb begin
    hit      = 1'b0;
    area_idx = '0;
    for (int i = 0; i < N_AREA; i++) begin
      if (area_hit[i] && !hit) begin
        hit      = 1'b1;
        area_idx = IDX_W'(i);
      end
    end
  end

  logic            wide;
  logic [MW_W-1:0] mode_word;
  logic            aligned;

  assign offset = addr[MW_W-1:0];

  always_comb begin
    wide = area_wide[area_idx];
    if (wide) begin
      mode_word = offset >> 2;
      aligned   = (offset[1:0] == 2'b00);
    end else begin
      mode_word = offset >> 1;
      aligned   = !offset[0];
    end
  end

  assign lat   = mode_word_lat(mode_word);
  assign legal = (size == SZ_BYTE) && cfg_done && aligned && mode_word_ok(mode_word);

endmodule

// File: rtl/mrs_tmrd_timer.sv
module mrs_tmrd_timer #(
  parameter int  TMRD = 2,
  localparam int CW   = $clog2(TMRD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(TMRD);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);

  // A command may only be issued on an area whose wait has run out
  assert_no_cmd_in_tmrd_R8: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

endmodule

// File: rtl/sdram_mrs_gen.sv
module sdram_mrs_gen
  import sdram_mrs_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          SD_AW      = 15,
  parameter int          N_AREA     = 2,
  parameter int          TMRD       = 2,
  parameter logic [31:0] WIN_BASE   = 32'hA4FD4000,
  parameter logic [31:0] WIN_STRIDE = 32'h00001000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_done,
  input  logic [N_AREA-1:0]     area_wide,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [1:0]            bus_size,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_ack,
  output logic                  bus_err,
  output logic [N_AREA-1:0]     sd_cs_n,
  output logic                  sd_ras_n,
  output logic                  sd_cas_n,
  output logic                  sd_we_n,
  output logic [SD_AW-1:0]      sd_addr,
  output logic [2*N_AREA-1:0]   cas_lat
);

  localparam int IDX_W  = (N_AREA > 1) ? $clog2(N_AREA) : 1;
  localparam int HI_W   = SD_AW - MW_W;

  // Write data plays no part in a mode write
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_legal;
  logic [MW_W-1:0]  dec_ofs;
  logic [1:0]       dec_lat;

  mrs_window_decode #(
    .ADDR_W     (ADDR_W),
    .N_AREA     (N_AREA),
    .WIN_BASE   (WIN_BASE),
    .WIN_STRIDE (WIN_STRIDE)
  ) u_decode (
    .addr      (bus_addr),
    .size      (bus_size),
    .cfg_done  (cfg_done),
    .area_wide (area_wide),
    .hit       (dec_hit),
    .area_idx  (dec_idx),
    .legal     (dec_legal),
    .offset    (dec_ofs),
    .lat       (dec_lat)
  );

  mrs_state_e       state;
  logic [N_AREA-1:0] area_busy;
  logic [N_AREA-1:0] area_load;
  logic             take;
  logic             issue;
  logic             reject;

  assign take   = (state == ST_IDLE) && bus_req && bus_we && dec_hit;
  assign reject = take && !dec_legal;
  assign issue  = take && dec_legal && !area_busy[dec_idx];

  // Independent tMRD wait per area
  for (genvar ga = 0; ga < N_AREA; ga++) begin : g_area
    assign area_load[ga] = issue && (dec_idx == IDX_W'(ga));
    mrs_tmrd_timer #(.TMRD(TMRD)) u_tmrd (
      .clk  (clk),
      .rst  (rst),
      .load (area_load[ga]),
      .busy (area_busy[ga])
    );
  end

  logic [N_AREA-1:0]      cs_q;
  logic                   ras_q, cas_q, we_q;
  logic [SD_AW-1:0]       addr_q;
  logic                   ack_q, err_q;
  logic [N_AREA-1:0][1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cs_q   <= '1;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      addr_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      lat_q  <= {N_AREA{2'd3}};
    end else begin
      cs_q  <= '1;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
      ack_q <= 1'b0;
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reject) begin
            ack_q <= 1'b1;
            err_q <= 1'b1;
            state <= ST_RESP;
          end else if (issue) begin
            cs_q[dec_idx]  <= 1'b0;
            ras_q          <= 1'b0;
            cas_q          <= 1'b0;
            we_q           <= 1'b0;
            addr_q         <= {{HI_W{1'b0}}, dec_ofs};
            lat_q[dec_idx] <= dec_lat;
            state          <= ST_CMD;
          end
        end
        ST_CMD: begin
          ack_q <= 1'b1;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sd_cs_n  = cs_q;
  assign sd_ras_n = ras_q;
  assign sd_cas_n = cas_q;
  assign sd_we_n  = we_q;
  assign sd_addr  = addr_q;
  assign bus_ack  = ack_q;
  assign bus_err  = err_q;
  assign cas_lat  = lat_q;

  // Command cycle selects exactly one area with all three strobes low
  assert_mrs_encoding_R2: assert property (@(posedge clk) disable iff (rst)
    !sd_ras_n |-> ($countones(~sd_cs_n) == 1 && !sd_cas_n && !sd_we_n));

  // Outside a command every strobe rests high
  assert_nop_rest_R2: assert property (@(posedge clk) disable iff (rst)
    (&sd_cs_n) |-> (sd_ras_n && sd_cas_n && sd_we_n));

  // The cycle after a command carries a clean acknowledge
  assert_ack_after_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    !sd_ras_n |=> (bus_ack && !bus_err));

  // Acknowledge never lasts beyond one cycle
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  // An error only appears on an acknowledge
  assert_err_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bus_ack);

endmodule

// File: tb/sdram_mrs_gen_tb.sv
module sdram_mrs_gen_tb;

  localparam int TMRD_TB = 4;
  localparam logic [31:0] W0 = 32'hA4FD4000;
  localparam logic [31:0] W1 = 32'hA4FD5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_done = 1'b0;
  logic [1:0]  area_wide = 2'b00;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = 2'b00;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack, bus_err;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [14:0] sd_addr;
  logic [3:0]  cas_lat;

  sdram_mrs_gen #(.TMRD(TMRD_TB)) u_dut (
    .clk, .rst, .cfg_done, .area_wide, .bus_req, .bus_we, .bus_addr,
    .bus_size, .bus_wdata, .bus_ack, .bus_err, .sd_cs_n, .sd_ras_n,
    .sd_cas_n, .sd_we_n, .sd_addr, .cas_lat
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_total = 0;
  int n_fail  = 0;

  // Results of the most recent bus write
  logic        r_ack, r_err, r_ok;
  int          r_ncmd, r_cmd_cyc, r_ack_cyc;
  logic [1:0]  r_cs;
  logic [14:0] r_addr;
  logic [1:0]  exp_lat [2];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where ack is seen
  task automatic bus_wr(input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic we, input int limit);
    r_ack = 0; r_err = 0; r_ok = 1; r_ncmd = 0; r_cs = '1; r_addr = '0;
    r_cmd_cyc = -1; r_ack_cyc = -1;
    bus_req = 1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = d;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (sd_cs_n != 2'b11) begin
        r_ncmd++; r_cs = sd_cs_n; r_addr = sd_addr; r_cmd_cyc = cyc;
        if (sd_ras_n | sd_cas_n | sd_we_n) r_ok = 0;
      end else if (!(sd_ras_n & sd_cas_n & sd_we_n)) begin
        r_ok = 0;
      end
      if (bus_ack) begin
        r_ack = 1; r_err = bus_err; r_ack_cyc = cyc;
        break;
      end
    end
    bus_req = 0; bus_we = 0;
  endtask

  task automatic chk_lat(input string tag);
    chk(cas_lat[1:0] == exp_lat[0], tag, cas_lat[1:0], exp_lat[0]);
    chk(cas_lat[3:2] == exp_lat[1], tag, cas_lat[3:2], exp_lat[1]);
  endtask

  task automatic t_reset;
    chk(sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n, "R10 strobes", sd_cs_n, 3);
    chk(!bus_ack && !bus_err, "R10 ack/err", {bus_ack, bus_err}, 0);
    chk(cas_lat == 4'hF, "R10 cas_lat", cas_lat, 4'hF);
  endtask

  task automatic t_before_cfg;
    bus_wr(W0 + 32'h440, 2'b00, 32'h0, 1, 10);
    chk(r_ack && r_err, "R5 err before cfg", {r_ack, r_err}, 3);
    chk(r_ncmd == 0, "R5 no command", r_ncmd, 0);
    chk_lat("R5 cas_lat kept");
  endtask

  task automatic t_legal;
    logic [31:0] ofs;
    for (int ar = 0; ar < 2; ar++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int m = 0; m < 4; m++) begin
          area_wide = wd[0] ? 2'b11 : 2'b00;
          ofs = (((m >= 2) ? 32'h200 : 32'h0) | (((m % 2) == 0) ? 32'h20 : 32'h30)) << (wd + 1);
          bus_wr((ar == 0 ? W0 : W1) + ofs, 2'b00, 32'hA5A5_0000 + ofs, 1, 40);
          exp_lat[ar] = ((m % 2) == 0) ? 2'd2 : 2'd3;
          chk(r_ack && !r_err, "R6 legal accepted", {r_ack, r_err}, 2);
          chk(r_ncmd == 1 && r_ok, "R2 one MRS cycle", r_ncmd, 1);
          chk(r_cs == (ar == 0 ? 2'b10 : 2'b01), "R1 area select", r_cs, (ar == 0 ? 2 : 1));
          chk(r_addr == ofs[14:0], "R3 address pins", r_addr, ofs);
          chk(r_ack_cyc == r_cmd_cyc + 1, "R7 ack timing", r_ack_cyc - r_cmd_cyc, 1);
          chk_lat("R9 cas_lat");
        end
      end
    end
  endtask

  task automatic t_bad_size;
    area_wide = 2'b00;
    for (int s = 1; s < 3; s++) begin
      bus_wr(W0 + 32'h460, s[1:0], 32'h0, 1, 10);
      chk(r_ack && r_err && r_ncmd == 0, "R4 non-byte rejected", {r_ack, r_err, r_ncmd[0]}, 6);
      chk(r_ack_cyc >= 0, "R7 reject acked", r_ack_cyc, 0);
      chk_lat("R4 cas_lat kept");
    end
  endtask

  task automatic t_bad_mode;
    logic [31:0] bad16 [5];
    bad16 = '{32'h880, 32'h444, 32'h441, 32'h4C0, 32'h450};
    area_wide = 2'b00;
    for (int i = 0; i < 5; i++) begin
      bus_wr(W1 + bad16[i], 2'b00, 32'h0, 1, 10);
      chk(r_ack && r_err && r_ncmd == 0, "R6 bad 16-bit offset", bad16[i], 0);
    end
    area_wide = 2'b11;
    bus_wr(W0 + 32'h440, 2'b00, 32'h0, 1, 10);
    chk(r_ack && r_err && r_ncmd == 0, "R6 16-bit offset on 32-bit area", r_ncmd, 0);
    bus_wr(W0 + 32'h882, 2'b00, 32'h0, 1, 10);
    chk(r_ack && r_err && r_ncmd == 0, "R6 misaligned 32-bit offset", r_ncmd, 0);
    chk_lat("R6 cas_lat kept");
  endtask

  task automatic t_outside;
    repeat (8) @(negedge clk);
    bus_wr(32'hA4FD6440, 2'b00, 32'h0, 1, 6);
    chk(!r_ack && r_ncmd == 0, "R1 above windows ignored", {r_ack, r_ncmd[0]}, 0);
    bus_wr(32'hA4FD3440, 2'b00, 32'h0, 1, 6);
    chk(!r_ack && r_ncmd == 0, "R1 below windows ignored", {r_ack, r_ncmd[0]}, 0);
    bus_wr(W0 + 32'h440, 2'b00, 32'h0, 0, 6);
    chk(!r_ack && r_ncmd == 0, "R1 read ignored", {r_ack, r_ncmd[0]}, 0);
  endtask

  task automatic t_data_ignored;
    logic [14:0] a0;
    area_wide = 2'b00;
    bus_wr(W0 + 32'h060, 2'b00, 32'h0000_0000, 1, 40);
    a0 = r_addr;
    bus_wr(W0 + 32'h060, 2'b00, 32'hFFFF_FFFF, 1, 40);
    chk(r_ack && !r_err && r_addr == a0 && a0 == 15'h060, "R3 data ignored", r_addr, 15'h060);
    chk(r_addr[14:12] == 3'b000, "R3 high pins zero", r_addr[14:12], 0);
    exp_lat[0] = 2'd3;
  endtask

  task automatic t_tmrd;
    int c1;
    area_wide = 2'b00;
    repeat (8) @(negedge clk);
    bus_wr(W0 + 32'h440, 2'b00, 32'h0, 1, 40);
    c1 = r_cmd_cyc;
    bus_wr(W0 + 32'h460, 2'b00, 32'h0, 1, 40);
    chk(r_ncmd == 1 && r_cmd_cyc - c1 == TMRD_TB + 1, "R8 same-area gap", r_cmd_cyc - c1, TMRD_TB + 1);
    exp_lat[0] = 2'd3;
    repeat (8) @(negedge clk);
    bus_wr(W0 + 32'h440, 2'b00, 32'h0, 1, 40);
    c1 = r_cmd_cyc;
    bus_wr(W1 + 32'h040, 2'b00, 32'h0, 1, 40);
    chk(r_ncmd == 1 && r_cmd_cyc - c1 == 3, "R8 other area not delayed", r_cmd_cyc - c1, 3);
    exp_lat[0] = 2'd2;
    exp_lat[1] = 2'd2;
    chk_lat("R9 per-area latency");
  endtask

  initial begin
    exp_lat[0] = 2'd3;
    exp_lat[1] = 2'd3;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_before_cfg();
    cfg_done = 1;
    t_legal();
    t_bad_size();
    t_bad_mode();
    t_outside();
    t_data_ignored();
    t_tmrd();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule